// File: doc/BRIEF.md
# Address Range Cache Maintenance Sequencer

This block turns a single range maintenance command into a stream of per-line requests toward a level-one cache. A command carries a start virtual address, an end virtual address and one of four operation kinds. The sequencer walks every 32-byte line from the line holding the start address through the line holding the end address. Both end lines are included. It presents one request per line on a valid/ready handshake.

The walk can be cut short in two ways. An interrupt request stops it before the next line is offered, and the issuer must then relaunch the whole command. A translation fault flagged on the line being offered aborts the walk and records that line's address. A per-line fault input stands in for the translation result. A cache miss is not visible here: the cache simply accepts the request. Exactly one of three one-cycle pulses (done, interrupted, aborted) closes every accepted command.

Top module: `range_maint_seq`

## Requirements
- R1: After reset, busy, req_valid, done, intr and abort are 0, fault_addr is 0 and cmd_ready is 1.
- R2: cmd_ready equals the inverse of busy. A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. While busy, cmd_valid and the command fields are ignored, and the walk in progress continues unchanged.
- R3: Each request address is a line address with bits [4:0] zero. The first request is the start address's line. The address advances by 32 only on a cycle where req_valid and req_ready are both 1, and it holds while the request is stalled.
- R4: A walk issues exactly (end line index − start line index + 1) accepted requests, where a line index is address bits [31:5]. The last request is the end line, and a start and end in the same line give exactly one request.
- R5: If the start line index is greater than the end line index, no request is presented and done pulses in the cycle after acceptance. A start byte address above the end byte address within the same line still gives one request.
- R6: done is high for one cycle, in the cycle after the end line's request is accepted, and busy is 0 in that same cycle.
- R7: When irq_req is high while busy, req_valid is 0 in that cycle. In the next cycle intr pulses for one cycle, busy is 0 and no further request of that command is presented.
- R8: When xlat_fault is high while busy, req_valid is 0 in that cycle. In the next cycle abort pulses and fault_addr holds the line address being offered. fault_addr keeps that value until the next abort. A fault has priority over a simultaneous irq_req.
- R9: req_op equals the op of the accepted command for the whole walk, with encoding 0 = invalidate instruction lines, 1 = invalidate data lines, 2 = clean data lines, 3 = clean and invalidate data lines.
- R10: While idle, irq_req and xlat_fault have no effect. No pulse is raised, no request is presented and fault_addr is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Range command offered |
| cmd_ready | output | 1 | Sequencer can take a command (idle) |
| cmd_start | input | 32 | First virtual address of the range |
| cmd_end | input | 32 | Last virtual address of the range |
| cmd_op | input | 2 | Operation kind, encoding as in R9 |
| irq_req | input | 1 | Interrupt request: stop the walk |
| xlat_fault | input | 1 | Translation of the offered line failed |
| req_valid | output | 1 | Line request offered to the cache |
| req_ready | input | 1 | Cache accepts the offered request |
| req_addr | output | 32 | Line address of the offered request |
| req_op | output | 2 | Operation kind of the offered request |
| busy | output | 1 | A command is being walked |
| done | output | 1 | One-cycle pulse: walk completed |
| intr | output | 1 | One-cycle pulse: walk interrupted, relaunch needed |
| abort | output | 1 | One-cycle pulse: walk aborted on a translation fault |
| fault_addr | output | 32 | Line address of the most recent fault |

## Verification
On every cycle the assertions check several local properties. No request is offered while idle, and a stalled request holds its address. Each accepted request moves the line by exactly one. At most one closing pulse is raised at a time. An abort reports the address offered in the cycle before, and busy has dropped whenever a closing pulse is seen. Other properties only show across a whole walk, and the bench's scenarios cover these. They include the exact number of requests for aligned, unaligned, single-line, reversed and top-of-memory ranges, and fault priority over a simultaneous interrupt. They also cover commands that are ignored while busy and stray irq or fault inputs while idle.

// File: rtl/rmseq_pkg.sv
// Shared types for the range maintenance sequencer.
package rmseq_pkg;

    // Operation kind carried by a command and echoed on each line request.
    typedef enum logic [1:0] {
        MOP_INV_INSN    = 2'd0,
        MOP_INV_DATA    = 2'd1,
        MOP_CLEAN_DATA  = 2'd2,
        MOP_CLNINV_DATA = 2'd3
    } maint_op_e;

    // Sequencer state.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WALK = 1'b1
    } seq_state_e;

    // How the current cycle closes a command, if it does.
    typedef enum logic [1:0] {
        FIN_NONE  = 2'd0,
        FIN_DONE  = 2'd1,
        FIN_INTR  = 2'd2,
        FIN_ABORT = 2'd3
    } finish_e;

endpackage

// File: rtl/rmseq_range_check.sv
// Range check: flags a command whose start line index lies above its end
// line index. Such a command performs no line operation.
// Assumes both indices are already stripped of the in-line offset bits.
module rmseq_range_check #(
    parameter int LIDX_W = 27
) (
    input  logic [LIDX_W-1:0] start_idx,
    input  logic [LIDX_W-1:0] end_idx,
    output logic              empty
);

    // Unsigned compare of line indices only.
    always_comb begin
        empty = (start_idx > end_idx);
    end

endmodule

// File: rtl/rmseq_line_ctr.sv
// Line counter: holds the current line index and the end line index of the
// walk, steps the current index by one line on request, and flags when the
// current line is the last of the range.
// Assumes load and advance are never asserted together by the controller.
module rmseq_line_ctr #(
    parameter int LIDX_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LIDX_W-1:0] load_start,
    input  logic [LIDX_W-1:0] load_end,
    input  logic              advance,
    output logic [LIDX_W-1:0] cur_idx,
    output logic              at_last
);

    logic [LIDX_W-1:0] end_q;

    // Current line: loaded on accept, stepped by one on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx <= '0;
        end else if (load) begin
            cur_idx <= load_start;
        end else if (advance) begin
            cur_idx <= cur_idx + 1'b1;
        end
    end

    // End line of the walk, captured once per command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q <= '0;
        end else if (load) begin
            end_q <= load_end;
        end
    end

    // Last-line flag compared on equality so a top-of-memory range ends cleanly.
    always_comb begin
        at_last = (cur_idx == end_q);
    end

    // R3: an accepted request moves the walk forward by exactly one line.
    p_step_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (cur_idx == $past(cur_idx) + 1'b1));

    // R4: the walk never steps past the end line.
    p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !at_last);

endmodule

// File: rtl/rmseq_ctrl.sv
// Controller: accepts a command when idle, gates the line request against
// interrupt and fault inputs, decides how each cycle may close the command,
// and raises the one-cycle closing pulses and the fault address.
// Assumes cur_line_addr is the address of the line currently offered.
module rmseq_ctrl
    import rmseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              empty,
    input  logic              at_last,
    input  logic              irq_req,
    input  logic              xlat_fault,
    input  logic              req_ready,
    input  logic [ADDR_W-1:0] cur_line_addr,
    output logic              cmd_ready,
    output logic              busy,
    output logic              req_valid,
    output logic [1:0]        req_op,
    output logic              load,
    output logic              advance,
    output logic              done,
    output logic              intr,
    output logic              abort,
    output logic [ADDR_W-1:0] fault_addr
);

    seq_state_e state_q;
    maint_op_e  op_q;
    finish_e    fin;
    logic       walking;
    logic       accept;
    logic       fire;

    // Handshake decode: accept when idle, offer a line only when unhindered.
    always_comb begin
        walking   = (state_q == SEQ_WALK);
        cmd_ready = !walking;
        busy      = walking;
        accept    = cmd_valid && !walking;
        load      = accept && !empty;
        req_valid = walking && !xlat_fault && !irq_req;
        fire      = req_valid && req_ready;
        advance   = fire && !at_last;
        req_op    = op_q;
    end

    // Closing decision: fault beats interrupt beats normal completion.
    always_comb begin
        fin = FIN_NONE;
        if (accept && empty) begin
            fin = FIN_DONE;
        end else if (walking) begin
            if (xlat_fault) begin
                fin = FIN_ABORT;
            end else if (irq_req) begin
                fin = FIN_INTR;
            end else if (fire && at_last) begin
                fin = FIN_DONE;
            end
        end
    end

    // State register: enter the walk on a non-empty accept, leave on any close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else if (load) begin
            state_q <= SEQ_WALK;
        end else if (fin != FIN_NONE) begin
            state_q <= SEQ_IDLE;
        end
    end

    // Operation kind captured with the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= MOP_INV_INSN;
        end else if (accept) begin
            op_q <= maint_op_e'(cmd_op);
        end
    end

    // Closing pulses, each one cycle long.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            intr  <= 1'b0;
            abort <= 1'b0;
        end else begin
            done  <= (fin == FIN_DONE);
            intr  <= (fin == FIN_INTR);
            abort <= (fin == FIN_ABORT);
        end
    end

    // Fault address: the offered line when a translation fault aborts the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr <= '0;
        end else if (fin == FIN_ABORT) begin
            fault_addr <= cur_line_addr;
        end
    end

    // R6: at most one closing pulse at a time.
    p_one_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, intr, abort}));

    // R10: nothing is offered while idle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    // R8: an abort reports the line offered in the cycle before.
    p_abort_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (fault_addr == $past(cur_line_addr)));

    // R7: the walk has stopped when the interrupted pulse appears.
    p_intr_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> (!busy && !req_valid));

    // R6: busy has dropped when done is raised.
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/range_maint_seq.sv
// Address range cache maintenance sequencer, top level.
// Splits a start/end virtual address range into per-line maintenance
// requests on a valid/ready handshake, inclusive of both end lines, with
// interrupt and translation-fault exits.
// Assumes the cache accepts one request per handshake and reports no miss.
module range_maint_seq #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_start,
    input  logic [ADDR_W-1:0] cmd_end,
    input  logic [1:0]        cmd_op,
    input  logic              irq_req,
    input  logic              xlat_fault,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        req_op,
    output logic              busy,
    output logic              done,
    output logic              intr,
    output logic              abort,
    output logic [ADDR_W-1:0] fault_addr
);

    localparam int LINE_OFS = $clog2(LINE_BYTES);
    localparam int LIDX_W   = ADDR_W - LINE_OFS;

    logic [LIDX_W-1:0] start_idx;
    logic [LIDX_W-1:0] end_idx;
    logic [LIDX_W-1:0] cur_idx;
    logic              empty;
    logic              at_last;
    logic              load;
    logic              advance;
    logic              unused_ofs;

    // Strip the in-line offset; only line indices steer the walk.
    always_comb begin
        start_idx  = cmd_start[ADDR_W-1:LINE_OFS];
        end_idx    = cmd_end[ADDR_W-1:LINE_OFS];
        req_addr   = {cur_idx, {LINE_OFS{1'b0}}};
        unused_ofs = ^{cmd_start[LINE_OFS-1:0], cmd_end[LINE_OFS-1:0]};
    end

    rmseq_range_check #(.LIDX_W(LIDX_W)) u_range (
        .start_idx (start_idx),
        .end_idx   (end_idx),
        .empty     (empty)
    );

    rmseq_line_ctr #(.LIDX_W(LIDX_W)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_start (start_idx),
        .load_end   (end_idx),
        .advance    (advance),
        .cur_idx    (cur_idx),
        .at_last    (at_last)
    );

    rmseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .empty         (empty),
        .at_last       (at_last),
        .irq_req       (irq_req),
        .xlat_fault    (xlat_fault),
        .req_ready     (req_ready),
        .cur_line_addr (req_addr),
        .cmd_ready     (cmd_ready),
        .busy          (busy),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .load          (load),
        .advance       (advance),
        .done          (done),
        .intr          (intr),
        .abort         (abort),
        .fault_addr    (fault_addr)
    );

    // R3: a stalled request keeps its line address and the walk stays live.
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_ready && !irq_req && !xlat_fault)
            |=> (busy && $stable(req_addr)));

    // R3: every offered address is line aligned.
    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[LINE_OFS-1:0] == '0));

endmodule

// File: tb/range_maint_seq_tb.sv
module range_maint_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_start = '0;
    logic [31:0] cmd_end = '0;
    logic [1:0]  cmd_op = '0;
    logic        irq_req = 1'b0;
    logic        xlat_fault = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [1:0]  req_op;
    logic        busy, done, intr, abort;
    logic [31:0] fault_addr;

    int n_tests = 0;
    int n_fail = 0;
    int n_req = 0;
    int n_done = 0;
    int n_intr = 0;
    int n_abort = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Behavioural reference state
    bit          m_busy = 0;
    longint      m_line = 0;
    longint      m_end = 0;
    logic [1:0]  m_op = 0;
    bit          m_done = 0, m_intr = 0, m_abort = 0;
    logic [31:0] m_fault = 0;

    always #5 clk = ~clk;

    range_maint_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_start(cmd_start), .cmd_end(cmd_end), .cmd_op(cmd_op),
        .irq_req(irq_req), .xlat_fault(xlat_fault), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_op(req_op),
        .busy(busy), .done(done), .intr(intr), .abort(abort),
        .fault_addr(fault_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic step(input logic cv, input logic [31:0] s, input logic [31:0] e,
                        input logic [1:0] op, input logic irq, input logic flt,
                        input logic rdy);
        logic exp_rv;
        @(negedge clk);
        cmd_valid = cv; cmd_start = s; cmd_end = e; cmd_op = op;
        irq_req = irq; xlat_fault = flt; req_ready = rdy;
        #1;
        exp_rv = m_busy && !flt && !irq;
        chk("R2 cmd_ready", {31'd0, cmd_ready}, {31'd0, !m_busy});
        chk("R2 busy", {31'd0, busy}, {31'd0, m_busy});
        chk("R3 req_valid", {31'd0, req_valid}, {31'd0, exp_rv});
        if (exp_rv) begin
            chk("R3 req_addr", req_addr, 32'(m_line * 32));
            chk("R9 req_op", {30'd0, req_op}, {30'd0, m_op});
        end
        chk("R6 done", {31'd0, done}, {31'd0, m_done});
        chk("R7 intr", {31'd0, intr}, {31'd0, m_intr});
        chk("R8 abort", {31'd0, abort}, {31'd0, m_abort});
        chk("R8 fault_addr", fault_addr, m_fault);
        if (req_valid && rdy) n_req++;
        if (done) n_done++;
        if (intr) n_intr++;
        if (abort) n_abort++;
        m_done = 0; m_intr = 0; m_abort = 0;
        if (!m_busy) begin
            if (cv) begin
                if ((s >> 5) > (e >> 5)) m_done = 1;
                else begin
                    m_busy = 1; m_line = s >> 5; m_end = e >> 5; m_op = op;
                end
            end
        end else if (flt) begin
            m_abort = 1; m_fault = 32'(m_line * 32); m_busy = 0;
        end else if (irq) begin
            m_intr = 1; m_busy = 0;
        end else if (rdy) begin
            if (m_line == m_end) begin m_done = 1; m_busy = 0; end
            else m_line++;
        end
    endtask

    // Launch one command and run it to its close; rmode 1 gives random stalls.
    task automatic run_cmd(input logic [31:0] s, input logic [31:0] e, input logic [1:0] op,
                           input int rmode, input int irq_at, input int flt_at,
                           input int junk);
        logic rdy;
        n_req = 0; n_done = 0; n_intr = 0; n_abort = 0;
        step(1'b1, s, e, op, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 400 && m_busy; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rdy = (rmode == 0) ? 1'b1 : lfsr[0];
            step((k < junk) ? 1'b1 : 1'b0, 32'h0000_9000, 32'h0000_9FFF, 2'd3,
                 k == irq_at, k == flt_at, rdy);
        end
        step(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
        chk("R1 pulses", {29'd0, done, intr, abort}, 32'd0);
        chk("R1 fault_addr", fault_addr, 32'd0);
        chk("R1 cmd_ready", {31'd0, cmd_ready}, 32'd1);
        rst_n = 1'b1;

        // R4/R9: aligned four-line walk, cache always ready
        run_cmd(32'h0000_1000, 32'h0000_107F, 2'd1, 0, -1, -1, 0);
        chk("R4 count aligned", n_req, 4);
        chk("R6 done once", n_done, 1);

        // R3/R4: unaligned ends with random stalls
        run_cmd(32'h0000_2013, 32'h0000_2041, 2'd2, 1, -1, -1, 0);
        chk("R4 count unaligned", n_req, 3);

        // R4: start and end inside one line
        run_cmd(32'h0000_3005, 32'h0000_301F, 2'd0, 0, -1, -1, 0);
        chk("R4 single line", n_req, 1);

        // R5: start line above end line
        run_cmd(32'h0000_4040, 32'h0000_4000, 2'd1, 0, -1, -1, 0);
        chk("R5 empty count", n_req, 0);
        chk("R5 empty done", n_done, 1);

        // R5: start byte above end byte in the same line
        run_cmd(32'h0000_4010, 32'h0000_4000, 2'd3, 0, -1, -1, 0);
        chk("R5 same line reversed", n_req, 1);

        // R2: commands offered while busy are ignored
        run_cmd(32'h0000_7000, 32'h0000_70FF, 2'd3, 0, -1, -1, 3);
        chk("R2 ignored while busy", n_req, 8);

        // R7: interrupt after three accepted lines
        run_cmd(32'h0000_6000, 32'h0000_60FF, 2'd2, 0, 3, -1, 0);
        chk("R7 count at intr", n_req, 3);
        chk("R7 intr once", n_intr, 1);
        chk("R7 no done", n_done, 0);

        // R8: fault on third line with a simultaneous interrupt
        run_cmd(32'h0000_5000, 32'h0000_50FF, 2'd1, 0, 2, 2, 0);
        chk("R8 count at fault", n_req, 2);
        chk("R8 abort once", n_abort, 1);
        chk("R8 fault beats intr", n_intr, 0);
        chk("R8 fault line", fault_addr, 32'h0000_5040);

        // R10: stray irq and fault while idle
        n_req = 0; n_intr = 0; n_abort = 0;
        for (int k = 0; k < 4; k++) step(1'b0, 0, 0, 0, 1'b1, 1'b1, 1'b1);
        step(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        chk("R10 no request", n_req, 0);
        chk("R10 no pulse", n_intr + n_abort, 0);
        chk("R10 fault_addr kept", fault_addr, 32'h0000_5040);

        // R4: range at the top of the address space, random stalls
        run_cmd(32'hFFFF_FFC0, 32'hFFFF_FFFF, 2'd0, 1, -1, -1, 0);
        chk("R4 top of memory", n_req, 2);

        // R3: long walk with stalls
        run_cmd(32'h0001_0000, 32'h0001_07E0, 2'd3, 1, -1, -1, 0);
        chk("R3 long walk", n_req, 64);

        summary();
    end

endmodule